// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO

This block is a first-in first-out buffer of 16 words, each 4 bits wide. It is built as a chain of register stages, and each stage has its own full bit. A word written at the input stage moves forward one stage per clock toward the output stage, as long as the stage ahead of it is empty. When the output stage is read, the gap left behind travels back toward the input, one stage per clock.

Both sides use a ready/strobe handshake. The write side raises `in_ready_o`, and a word is taken when `shift_in_i` is high in the same cycle. The read side raises `out_ready_o`, and the head word is removed when `shift_out_i` is high in the same cycle. The data outputs are three-state and are driven only while `oe_i` is high. The active-low asynchronous reset empties every stage.

The handshake is shaped for direct chaining. One unit's `out_ready_o` drives the next unit's `shift_in_i`, and the next unit's `in_ready_o` drives the previous unit's `shift_out_i`. A chain of N units gives 16×N words with no glue logic.

Top module: `shift_fifo`

## Requirements
- R1: While reset is active, and after it until the first write, `in_ready_o` is 1 and `out_ready_o` is 0.
- R2: A `shift_in_i` pulse while `in_ready_o` is 0 stores nothing. The buffer stays full, and the word on `data_i` never appears at the output.
- R3: A `shift_out_i` pulse while `out_ready_o` is 0 removes nothing. A word written afterwards is still delivered, exactly once.
- R4: The buffer holds 16 words. After 16 accepted writes with no reads, once motion has settled, `in_ready_o` is 0 and the words come out in write order.
- R5: A word written into an empty buffer sets `out_ready_o` 15 clock edges after the edge that wrote it (DEPTH-1).
- R6: While `out_ready_o` is 1 and no read is made, `out_ready_o` stays 1 and the output word does not change.
- R7: With `oe_i` at 0, every bit of `data_o` is high impedance. With `oe_i` at 1, `data_o` carries the head word.
- R8: When `in_ready_o` and `out_ready_o` are both 1, a write and a read in the same cycle both take effect, and order is kept.
- R9: After one read from a full buffer, `in_ready_o` returns 15 clock edges after the read edge (DEPTH-1), while the gap ripples back to the input.
- R10: Two units chained as described hold 32 words and pass them through in order, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset that empties all stages |
| data_i | input | WIDTH | Word to write |
| shift_in_i | input | 1 | Write strobe, taken only when `in_ready_o` is 1 |
| in_ready_o | output | 1 | Input stage is empty |
| shift_out_i | input | 1 | Read strobe, taken only when `out_ready_o` is 1 |
| out_ready_o | output | 1 | Output stage holds a stable word |
| oe_i | input | 1 | Output enable for `data_o` |
| data_o | output | WIDTH | Head word, high impedance while `oe_i` is 0 |

## Verification
The hardest state to reach from the ports is a full buffer in which a single gap is still travelling back toward the input. The flags then look frozen for many cycles, while the stages inside are still moving. The bench fills the buffer from a vector table, waits for it to settle, and strobes in while it is full. It then makes one read and counts the edges until `in_ready_o` returns. The chained pair is filled to its combined capacity of 32 words before any read, so every handshake between the two units is exercised under back-pressure.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  parameter int unsigned FIFO_WIDTH_DEF = 4;
  parameter int unsigned FIFO_DEPTH_DEF = 16;
endpackage

// File: rtl/fifo_stage.sv
module fifo_stage #(
  parameter int unsigned WIDTH = fifo_pkg::FIFO_WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             release_i,
  output logic             full_o,
  output logic [WIDTH-1:0] data_o
);
  // take_i needs an empty stage and release_i a full one, so they never coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (take_i) begin
      full_o <= 1'b1;
      data_o <= data_i;
    end else if (release_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fifo_tri_drv.sv
module fifo_tri_drv #(
  parameter int unsigned WIDTH = fifo_pkg::FIFO_WIDTH_DEF
) (
  input  logic             oe_i,
  input  logic [WIDTH-1:0] data_i,
  output wire  [WIDTH-1:0] pad_o
);
  assign pad_o = oe_i ? data_i : {WIDTH{1'bz}};
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo #(
  parameter int unsigned WIDTH = fifo_pkg::FIFO_WIDTH_DEF,
  parameter int unsigned DEPTH = fifo_pkg::FIFO_DEPTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_in_i,
  output logic             in_ready_o,
  input  logic             shift_out_i,
  output logic             out_ready_o,
  input  logic             oe_i,
  output wire  [WIDTH-1:0] data_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] full;
  logic [DEPTH-1:0] take;
  logic [DEPTH-1:0] rel;
  logic [WIDTH-1:0] word [DEPTH];
  logic [WIDTH-1:0] src  [DEPTH];
  logic [WIDTH-1:0] head;
  logic             push;
  logic             pop;

  assign push        = shift_in_i & ~full[0];
  assign pop         = shift_out_i & full[LAST];
  assign in_ready_o  = ~full[0];
  assign out_ready_o = full[LAST];
  assign head        = word[LAST];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_in
      assign take[k] = push;
      assign src[k]  = data_i;
    end else begin : g_mid
      // advance only into an empty stage
      assign take[k] = full[k-1] & ~full[k];
      assign src[k]  = word[k-1];
    end

    if (k == LAST) begin : g_out
      assign rel[k] = pop;
    end else begin : g_fwd
      assign rel[k] = take[k+1];
    end

    fifo_stage #(.WIDTH(WIDTH)) u_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .take_i   (take[k]),
      .data_i   (src[k]),
      .release_i(rel[k]),
      .full_o   (full[k]),
      .data_o   (word[k])
    );
  end

  fifo_tri_drv #(.WIDTH(WIDTH)) u_drv (
    .oe_i  (oe_i),
    .data_i(head),
    .pad_o (data_o)
  );
endmodule

// File: rtl/shift_fifo_chk.sv
module shift_fifo_chk #(
  parameter int unsigned WIDTH = fifo_pkg::FIFO_WIDTH_DEF,
  parameter int unsigned DEPTH = fifo_pkg::FIFO_DEPTH_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_in_i,
  input logic             shift_out_i,
  input logic             in_ready_o,
  input logic             out_ready_o,
  input logic [WIDTH-1:0] head,
  input logic [DEPTH-1:0] full
);
  logic wr_ok, rd_ok;
  assign wr_ok = shift_in_i & in_ready_o;
  assign rd_ok = shift_out_i & out_ready_o;

  a_r1_empty_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(full) == 0) |-> (in_ready_o && !out_ready_o));

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_in_i && !in_ready_o && !rd_ok) |=> ($countones(full) == $past($countones(full))));

  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_out_i && !out_ready_o && !wr_ok) |=> ($countones(full) == $past($countones(full))));

  a_r4_write_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !rd_ok) |=> ($countones(full) == $past($countones(full)) + 1));

  a_r6_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_ready_o && !shift_out_i) |=> (out_ready_o && $stable(head)));

  a_r8_both_sides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && rd_ok) |=> ($countones(full) == $past($countones(full))));
endmodule

bind shift_fifo shift_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shift_in_i (shift_in_i),
  .shift_out_i(shift_out_i),
  .in_ready_o (in_ready_o),
  .out_ready_o(out_ready_o),
  .head       (head),
  .full       (full)
);

// File: tb/tb_shift_fifo.sv
`timescale 1ns/1ps
module tb_shift_fifo;
  localparam int W = 4;
  localparam int D = 16;
  localparam logic [W-1:0] VEC [16] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'h9,
                                        4'h0, 4'hF, 4'h5, 4'hA, 4'h7, 4'hB, 4'hD, 4'h1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] din = '0;
  logic si = 1'b0, so = 1'b0, oe = 1'b1;
  wire  [W-1:0] dq;
  wire  ir, orr;

  shift_fifo #(.WIDTH(W), .DEPTH(D)) dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din), .shift_in_i(si), .in_ready_o(ir),
    .shift_out_i(so), .out_ready_o(orr), .oe_i(oe), .data_o(dq));

  for (genvar i = 0; i < W; i++) begin : g_pu
    pullup pu (dq[i]);
  end

  // chained pair
  logic [W-1:0] c_din = '0;
  logic c_si = 1'b0, c_so = 1'b0;
  wire  [W-1:0] mid, c_dq;
  wire  c0_ir, c0_or, c1_ir, c1_or;

  shift_fifo #(.WIDTH(W), .DEPTH(D)) c0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(c_din), .shift_in_i(c_si), .in_ready_o(c0_ir),
    .shift_out_i(c1_ir), .out_ready_o(c0_or), .oe_i(1'b1), .data_o(mid));
  shift_fifo #(.WIDTH(W), .DEPTH(D)) c1 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(mid), .shift_in_i(c0_or), .in_ready_o(c1_ir),
    .shift_out_i(c_so), .out_ready_o(c1_or), .oe_i(1'b1), .data_o(c_dq));

  int checks = 0;
  int errors = 0;
  logic [W-1:0] ref_q [$];
  logic [W-1:0] ref2_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic push(input logic [W-1:0] w);
    while (!ir) @(negedge clk);
    din = w;
    si  = 1'b1;
    @(negedge clk);
    si  = 1'b0;
    ref_q.push_back(w);
  endtask

  task automatic pop_chk(input string req);
    logic [W-1:0] e;
    while (!orr) @(negedge clk);
    e = ref_q.pop_front();
    chk(dq == e, req, int'(dq), int'(e));
    so = 1'b1;
    @(negedge clk);
    so = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    int n;
    bit ok;
    repeat (3) @(negedge clk);
    chk(ir == 1'b1, "R1 in_ready in reset", int'(ir), 1);
    chk(orr == 1'b0, "R1 out_ready in reset", int'(orr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ir == 1'b1 && orr == 1'b0, "R1 after reset", int'({ir, orr}), 2);

    // R5 fall-through latency
    din = 4'h9; si = 1'b1;
    @(negedge clk);
    si = 1'b0;
    ref_q.push_back(4'h9);
    n = 0;
    while (!orr && n < 100) begin @(negedge clk); n++; end
    chk(n == D - 1, "R5 latency", n, D - 1);

    // R6 head holds while unread
    ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!orr || dq != 4'h9) ok = 1'b0;
    end
    chk(ok, "R6 hold", int'(dq), 9);
    pop_chk("R6 read");
    @(negedge clk);
    chk(orr == 1'b0, "R3 empty after read", int'(orr), 0);

    // R3 reads on empty ignored
    so = 1'b1;
    repeat (4) @(negedge clk);
    so = 1'b0;
    chk(orr == 1'b0, "R3 still empty", int'(orr), 0);
    push(4'h3);
    pop_chk("R3 delivered");
    repeat (20) @(negedge clk);
    chk(orr == 1'b0, "R3 no duplicate", int'(orr), 0);

    // R4 fill from the vector table
    for (int i = 0; i < 16; i++) push(VEC[i]);
    repeat (40) @(negedge clk);
    chk(ir == 1'b0, "R4 full", int'(ir), 0);
    chk(orr == 1'b1, "R4 head ready", int'(orr), 1);

    // R2 writes while full ignored
    din = 4'hE; si = 1'b1;
    repeat (3) @(negedge clk);
    si = 1'b0;
    chk(ir == 1'b0, "R2 still full", int'(ir), 0);

    // R9 bubble ripple back to input
    chk(dq == ref_q[0], "R9 head", int'(dq), int'(ref_q[0]));
    void'(ref_q.pop_front());
    so = 1'b1;
    @(negedge clk);
    so = 1'b0;
    n = 0;
    while (!ir && n < 100) begin @(negedge clk); n++; end
    chk(n == D - 1, "R9 ripple", n, D - 1);
    push(4'h0);
    while (ref_q.size() > 0) pop_chk("R4 order");

    // R7 output enable
    push(4'h5);
    while (!orr) @(negedge clk);
    oe = 1'b0;
    @(negedge clk);
    chk(dq == 4'hF, "R7 high-z pulled", int'(dq), 15);
    oe = 1'b1;
    @(negedge clk);
    chk(dq == 4'h5, "R7 driven", int'(dq), 5);
    pop_chk("R7 read");

    // R8 simultaneous read and write
    push(4'h1); push(4'h2); push(4'h3);
    while (!(ir && orr)) @(negedge clk);
    chk(dq == ref_q[0], "R8 head", int'(dq), int'(ref_q[0]));
    void'(ref_q.pop_front());
    ref_q.push_back(4'hA);
    din = 4'hA; si = 1'b1; so = 1'b1;
    @(negedge clk);
    si = 1'b0; so = 1'b0;
    while (ref_q.size() > 0) pop_chk("R8 order");
    repeat (30) @(negedge clk);
    chk(orr == 1'b0, "R8 drained", int'(orr), 0);

    // R10 chained pair
    for (int i = 0; i < 32; i++) begin
      logic [W-1:0] w;
      w = W'((i * 7 + 3) % 16);
      while (!c0_ir) @(negedge clk);
      c_din = w; c_si = 1'b1;
      @(negedge clk);
      c_si = 1'b0;
      ref2_q.push_back(w);
    end
    repeat (100) @(negedge clk);
    chk(c0_ir == 1'b0, "R10 pair full", int'(c0_ir), 0);
    chk(c1_or == 1'b1, "R10 pair head", int'(c1_or), 1);
    for (int i = 0; i < 32; i++) begin
      logic [W-1:0] e;
      while (!c1_or) @(negedge clk);
      e = ref2_q.pop_front();
      chk(c_dq == e, "R10 order", int'(c_dq), int'(e));
      c_so = 1'b1;
      @(negedge clk);
      c_so = 1'b0;
    end
    repeat (100) @(negedge clk);
    chk(c1_or == 1'b0, "R10 no extra word", int'(c1_or), 0);
    chk(c0_ir == 1'b1, "R10 pair empty", int'(c0_ir), 1);

    report();
    $finish;
  end
endmodule